// File: doc/BRIEF.md
# Two-Channel Microsecond Interval Timer

This block holds two independent interval channels behind a small register window. Each channel has a count word and a limit word. Software arms a channel by writing its limit word. The interval length, in microseconds, sits in the 21-bit field at bits 30:10 of that word. A per-channel prescaler, sized from the input clock frequency, produces the microsecond ticks that drive a countdown. When the countdown reaches its end, the channel marks expiry by setting bit 31 in both of its words and stops.

A separate interrupt-control byte gates the two interrupt outputs. Bit 0 is a global enable. Bit 5 enables channel 0 and bit 7 enables channel 1. A channel's interrupt line is set at expiry only if its own enable bit and the global bit are both set at that moment. The line then stays high until software reads that channel's limit word.

Only the two low word-select bits reach the block, so the four-word window repeats across whatever address region the surrounding decoder assigns to it.

Top module: `usec_limit_timer`

## Requirements
- R1: After reset, all four words read 0, the control byte is 0 and both interrupt outputs are low.
- R2: Word select 0/1/2/3 addresses count 0, limit 0, count 1 and limit 1. A write updates only the byte lanes whose `bus_wstrb` bit is set (bit n covers data bits 8n+7:8n). Read data appears on `bus_rdata` one cycle after the read request.
- R3: A write to a limit word with period field P (bits 30:10), P nonzero, expires the channel exactly P*DIV clock edges after the write edge, where DIV = CLK_HZ/1_000_000. At expiry the count word becomes 0x80000400 and bit 31 of the limit word is set, with the limit word's other bits unchanged.
- R4: A limit write whose period field is 0 never expires. The interrupt output stays low and neither word changes.
- R5: Channel 0 expiry raises `irq_ch0` only if control bits 5 and 0 are both 1.
- R6: Channel 1 expiry raises `irq_ch1` only if control bits 7 and 0 are both 1.
- R7: A read of a channel's limit word drops that channel's interrupt. Reads of count words or of the other channel's limit word leave it high.
- R8: The control byte reads back on `ctl_q` exactly as last written.
- R9: Writing a limit word again while the channel is counting restarts the full interval from the new write.
- R10: A write with all byte strobes clear changes nothing and does not start a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word select within the window |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Registered read data |
| ctl_we | input | 1 | Control byte write enable |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_q | output | 8 | Control byte readback |
| irq_ch0 | output | 1 | Channel 0 interrupt |
| irq_ch1 | output | 1 | Channel 1 interrupt |

## Verification
The bench builds the block with CLK_HZ set to 3 MHz, so DIV is 3. This keeps every interval short enough to sweep periods 1 through 10 on both channels against all eight combinations of the three gating bits. The expiry edge is predicted as P*3 edges after the write, and the bench checks the cycle just before it as well as the expiry cycle itself. A divider of 3 also makes the prescaler wrap within each microsecond, so the restart case and the zero-strobe case can be checked in cycles rather than in real microseconds.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int          WORD_W   = 32;
  localparam int          LANES    = WORD_W / 8;
  localparam int          PER_LSB  = 10;
  localparam int          PER_W    = 21;
  localparam int          FLAG_BIT = 31;
  localparam logic [WORD_W-1:0] EXPIRED_COUNT = 32'h8000_0400;

  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] old_v,
    input logic [WORD_W-1:0] new_v,
    input logic [LANES-1:0]  strb
  );
    logic [WORD_W-1:0] r;
    for (int b = 0; b < LANES; b++)
      r[b*8 +: 8] = strb[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/tmr_usec_div.sv
module tmr_usec_div #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart)  pre_q <= '0;
    else if (run)        pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  assign tick = run && (pre_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      p_tick_spaced_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DIV = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cnt,
  input  logic              wr_lim,
  input  logic              rd_lim,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wstrb,
  input  logic              irq_gate,
  output logic [WORD_W-1:0] cnt_q,
  output logic [WORD_W-1:0] lim_q,
  output logic              irq_q
);
  logic [PER_W-1:0]  rem_q;
  logic              run_q;
  logic              tick;
  logic [WORD_W-1:0] lim_new;
  logic [PER_W-1:0]  new_period;
  logic              start;
  logic              expire;

  assign lim_new    = lane_merge(lim_q, wdata, wstrb);
  assign new_period = lim_new[PER_LSB +: PER_W];
  assign start      = wr_lim && (|wstrb);
  assign expire     = tick && (rem_q == PER_W'(1)) && !start;

  tmr_usec_div #(.DIV(DIV)) i_div (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (run_q),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= '0;
      rem_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      lim_q <= lim_new;
      rem_q <= new_period;
      run_q <= |new_period;
    end else if (tick) begin
      if (rem_q == PER_W'(1)) begin
        run_q           <= 1'b0;
        rem_q           <= '0;
        lim_q[FLAG_BIT] <= 1'b1;
      end else begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (expire)  cnt_q <= EXPIRED_COUNT;
    else if (wr_cnt)  cnt_q <= lane_merge(cnt_q, wdata, wstrb);
  end

  always_ff @(posedge clk) begin
    if (rst)                      irq_q <= 1'b0;
    else if (expire && irq_gate)  irq_q <= 1'b1;
    else if (rd_lim)              irq_q <= 1'b0;
  end

  p_expiry_flags_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (lim_q[FLAG_BIT] && cnt_q == EXPIRED_COUNT));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_lim && !expire) |=> !irq_q);

  p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start) |=> $stable(lim_q));
endmodule

// File: rtl/usec_limit_timer.sv
module usec_limit_timer
  import tmr_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  bus_wstrb,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_q,
  output logic              irq_ch0,
  output logic              irq_ch1
);
  localparam int DIV_RAW = CLK_HZ / 1_000_000;
  localparam int DIV     = (DIV_RAW > 0) ? DIV_RAW : 1;
  localparam int NCH     = 2;
  localparam int GLB_BIT = 0;

  logic [WORD_W-1:0] cnt_w [NCH];
  logic [WORD_W-1:0] lim_w [NCH];
  logic [NCH-1:0]    irq_w;

  always_ff @(posedge clk) begin
    if (rst)          ctl_q <= '0;
    else if (ctl_we)  ctl_q <= ctl_wdata;
  end

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam int EN_BIT = (ch == 0) ? 5 : 7;
      logic hit;
      assign hit = bus_en && (bus_addr[1] == 1'(ch));
      tmr_channel #(.DIV(DIV)) i_chan (
        .clk      (clk),
        .rst      (rst),
        .wr_cnt   (hit && bus_wr && !bus_addr[0]),
        .wr_lim   (hit && bus_wr && bus_addr[0]),
        .rd_lim   (hit && !bus_wr && bus_addr[0]),
        .wdata    (bus_wdata),
        .wstrb    (bus_wstrb),
        .irq_gate (ctl_q[EN_BIT] && ctl_q[GLB_BIT]),
        .cnt_q    (cnt_w[ch]),
        .lim_q    (lim_w[ch]),
        .irq_q    (irq_w[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_en && !bus_wr)
      bus_rdata <= bus_addr[0] ? lim_w[bus_addr[1]] : cnt_w[bus_addr[1]];
  end

  assign irq_ch0 = irq_w[0];
  assign irq_ch1 = irq_w[1];

  p_gate_ch0_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ch0) |-> $past(ctl_q[5] && ctl_q[0]));

  p_gate_ch1_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ch1) |-> $past(ctl_q[7] && ctl_q[0]));
endmodule

// File: tb/test_usec_limit_timer.sv
module test_usec_limit_timer;
  localparam int CLK_HZ = 3_000_000;
  localparam int DIV    = CLK_HZ / 1_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_q;
  logic        irq_ch0, irq_ch1;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  usec_limit_timer #(.CLK_HZ(CLK_HZ)) i_usec_limit_timer (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .irq_ch0(irq_ch0), .irq_ch1(irq_ch1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd_word(input logic [1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  function automatic logic irq_of(input int ch);
    return (ch == 0) ? irq_ch0 : irq_ch1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq0", 32'(irq_ch0), 0);
    chk("R1 irq1", 32'(irq_ch1), 0);
    chk("R1 ctl", 32'(ctl_q), 0);
    for (int w = 0; w < 4; w++) begin
      rd_word(2'(w), rv);
      chk("R1 word", rv, 0);
    end

    // R2 byte-lane merge and word map
    wr_word(2'd0, 32'h1122_3344, 4'hF);
    wr_word(2'd0, 32'hAABB_CCDD, 4'b0100);
    rd_word(2'd0, rv); chk("R2 merge cnt0", rv, 32'h11BB_3344);
    wr_word(2'd2, 32'hDEAD_BEEF, 4'b1001);
    rd_word(2'd2, rv); chk("R2 merge cnt1", rv, 32'hDE00_00EF);
    rd_word(2'd0, rv); chk("R2 cnt0 untouched", rv, 32'h11BB_3344);

    // R8 control byte readback sweep
    for (int v = 0; v < 256; v++) begin
      wr_ctl(8'(v));
      chk("R8 ctl readback", 32'(ctl_q), 32'(v));
    end

    // R3 R5 R6 R7 sweep over channel, period and gating bits
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 1; p <= 10; p++) begin
        for (int g = 0; g < 8; g++) begin
          logic [7:0]  cv;
          logic [31:0] lw;
          logic        exp_irq;
          cv = {g[2], 1'b0, g[1], 4'b0000, g[0]};
          exp_irq = g[0] && ((ch == 0) ? g[1] : g[2]);
          lw = (32'(p) << 10) | 32'((p * 37) & 10'h3FF);
          wr_ctl(cv);
          wr_word(2'(2 * ch), 32'h0, 4'hF);
          wr_word(2'(2 * ch + 1), lw, 4'hF);
          repeat (p * DIV - 1) @(posedge clk);
          @(negedge clk);
          chk("R3 no early expiry", 32'(irq_of(ch)), 0);
          @(posedge clk);
          @(negedge clk);
          chk(ch == 0 ? "R5 gated irq0" : "R6 gated irq1", 32'(irq_of(ch)), 32'(exp_irq));
          chk("R5 R6 other line low", 32'(irq_of(1 - ch)), 0);
          rd_word(2'(2 * ch), rv);
          chk("R3 count word", rv, 32'h8000_0400);
          chk("R7 count read keeps irq", 32'(irq_of(ch)), 32'(exp_irq));
          rd_word(2'(2 * (1 - ch) + 1), rv);
          chk("R7 other limit read keeps irq", 32'(irq_of(ch)), 32'(exp_irq));
          rd_word(2'(2 * ch + 1), rv);
          chk("R3 limit flag", rv, lw | 32'h8000_0000);
          chk("R7 limit read clears", 32'(irq_of(ch)), 0);
        end
      end
    end

    // R4 zero period
    wr_ctl(8'hA1);
    wr_word(2'd0, 32'h0, 4'hF);
    wr_word(2'd1, 32'h0000_03FF, 4'hF);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R4 no irq", 32'(irq_ch0), 0);
    rd_word(2'd0, rv); chk("R4 count unchanged", rv, 0);
    rd_word(2'd1, rv); chk("R4 limit unchanged", rv, 32'h0000_03FF);

    // R9 restart on rewrite
    wr_word(2'd3, 32'h0000_1400, 4'hF);
    repeat (10) @(posedge clk);
    @(negedge clk);
    wr_word(2'd3, 32'h0000_1400, 4'hF);
    repeat (5 * DIV - 1) @(posedge clk);
    @(negedge clk);
    chk("R9 not expired before restart interval", 32'(irq_ch1), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 expires after full restart interval", 32'(irq_ch1), 1);
    rd_word(2'd3, rv);
    chk("R9 limit flag", rv, 32'h8000_1400);

    // R10 zero-strobe write ignored
    wr_word(2'd1, 32'h0000_0400, 4'h0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R10 no start", 32'(irq_ch0), 0);
    rd_word(2'd1, rv); chk("R10 limit unchanged", rv, 32'h0000_03FF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule